// File: doc/BRIEF.md
# Calendar Clock Register Bank with Freezable User Copy

This block keeps time of day and calendar date in two copies. The first copy is a set of internal BCD counters for seconds, minutes, hours, weekday, date, month and year. They advance on a one-cycle pulse that arrives once per second. The second copy is a set of user registers that a host reads and writes through a synchronous register port. While the block runs freely, each second pulse reloads every user register from the freshly advanced counters in that same clock cycle.

A hold bit in the control register lets the host freeze the user copy. The host can then read a snapshot that cannot change between two reads, or compose a new time field by field. The internal counters go on counting while the user copy is frozen. A per-field written-while-held mask records which user registers the host changed. When the hold bit is cleared, only those fields are pushed into the counters, and the next second pulse refreshes the whole user copy.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After reset the user registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and the control register reads 0x00. The field addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year.
- R2: While the hold bit is 0, a second pulse loads every user register from the advanced counters at the clock edge that samples the pulse.
- R3: Seconds and minutes count in BCD from 0x59 to 0x00 and carry into the next field. Hours run in 24-hour form and go from 0x23 to 0x00, advancing both the weekday and the date. The weekday goes from 0x07 to 0x01.
- R4: The date wraps to 0x01 after 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after 0x30 in months 04, 06, 09 and 11. In month 02 it wraps after 0x29 when the BCD year is a multiple of four, and after 0x28 otherwise. The month goes from 0x12 to 0x01 and carries into the year, and the year goes from 0x99 to 0x00.
- R5: The control register sits at address 0xE, and the hold bit is bit 3, so a read returns 0x08 or 0x00. Other control bits read as 0. Addresses 0x7 to 0xD and 0xF read 0x00, and writes to them change nothing.
- R6: While the hold bit is 1, second pulses leave the user registers unchanged, but the internal counters keep advancing.
- R7: A second pulse in the same cycle as the write that sets the hold bit still reloads the user registers.
- R8: A field written while the hold bit is 1 reads back the written value at once. When the hold bit is cleared, the written fields are loaded into the counters, and fields that were not written keep their counted values.
- R9: A field written while the hold bit is 0 updates both the user register and the counter, and the next pulse counts on from the written value.
- R10: After the hold bit is cleared, the user registers keep their frozen values until the next second pulse reloads them.
- R11: When the hold bit is cleared in the same cycle as a second pulse, the written fields take their written values and all other fields take the values after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data, BCD for time fields |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational by default) |

## Verification
The second pulse can fall in the same cycle as a write to the hold bit, in either direction. The bench drives both on one clock edge. When the pulse coincides with setting the hold bit, the user registers must show the advanced time right after the edge. When it coincides with clearing the bit, the fields written while frozen must keep their written values, and the other fields must show the one-second advance after the next pulse. Sweeps over every month and every year in both leap and plain years, together with long tick runs, put the carry chain under the same comparison against arithmetic.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
package rtc_shadow_pkg;

   localparam int NF      = 7;
   localparam int F_SEC   = 0;
   localparam int F_MIN   = 1;
   localparam int F_HOUR  = 2;
   localparam int F_WDAY  = 3;
   localparam int F_DATE  = 4;
   localparam int F_MONTH = 5;
   localparam int F_YEAR  = 6;

   // lowest legal value of each field, also the reset value
   localparam logic [NF-1:0][7:0] FIELD_FLOOR =
      {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // year given as two BCD digits; multiple of four test
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

endpackage

// File: rtl/rtc_time_count.sv
`timescale 1ns/1ps
module rtc_time_count
   import rtc_shadow_pkg::*;
#(
   parameter int DW      = 8,
   parameter bit LEAP_EN = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [NF-1:0]         load_mask,
   input  logic [NF-1:0][DW-1:0] load_val,
   output logic [NF-1:0][DW-1:0] cnt_q,
   output logic [NF-1:0][DW-1:0] cnt_d
);

   logic [NF-1:0]         ci;
   logic [NF-1:0]         at_lim;
   logic [NF-1:0][DW-1:0] lim;
   logic [NF-1:0][DW-1:0] adv;
   logic [DW-1:0]         feb_len;
   logic [DW-1:0]         mlen;
   logic                  c_min, c_hr, c_day, c_mon, c_yr;

   generate
      if (LEAP_EN) begin : g_leap
         assign feb_len = bcd_leap(cnt_q[F_YEAR]) ? 8'h29 : 8'h28;
      end else begin : g_plain
         assign feb_len = 8'h28;
      end
   endgenerate

   always_comb begin
      case (cnt_q[F_MONTH])
         8'h02:                      mlen = feb_len;
         8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
         default:                    mlen = 8'h31;
      endcase
   end

   assign lim = {8'h99, 8'h12, mlen, 8'h07, 8'h23, 8'h59, 8'h59};

   // carry chain: weekday and date share the hour carry
   assign c_min = tick  & at_lim[F_SEC];
   assign c_hr  = c_min & at_lim[F_MIN];
   assign c_day = c_hr  & at_lim[F_HOUR];
   assign c_mon = c_day & at_lim[F_DATE];
   assign c_yr  = c_mon & at_lim[F_MONTH];
   assign ci    = {c_yr, c_mon, c_day, c_day, c_hr, c_min, tick};

   generate
      for (genvar i = 0; i < NF; i++) begin : g_field
         assign at_lim[i] = cnt_q[i] >= lim[i];
         assign adv[i]    = !ci[i]    ? cnt_q[i] :
                            at_lim[i] ? FIELD_FLOOR[i] : bcd_inc(cnt_q[i]);
         assign cnt_d[i]  = load_mask[i] ? load_val[i] : adv[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= FIELD_FLOOR;
      else        cnt_q <= cnt_d;
   end

endmodule

// File: rtl/rtc_user_bank.sv
`timescale 1ns/1ps
module rtc_user_bank
   import rtc_shadow_pkg::*;
#(
   parameter int          AW        = 4,
   parameter int          DW        = 8,
   parameter int unsigned CTRL_ADDR = 14,
   parameter int          INH_BIT   = 3,
   parameter bit          REG_RD    = 1'b0
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [AW-1:0]         addr,
   input  logic                  wr_en,
   input  logic [DW-1:0]         wr_data,
   input  logic [NF-1:0][DW-1:0] cnt_d,
   output logic [NF-1:0]         load_mask,
   output logic [NF-1:0][DW-1:0] load_val,
   output logic [NF-1:0][DW-1:0] usr_q,
   output logic [NF-1:0]         dirty_q,
   output logic                  inh_q,
   output logic [DW-1:0]         rd_data
);

   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
   localparam logic [AW-1:0] NF_A   = AW'(NF);

   logic                  wr_fld, wr_ctl, release_h;
   logic [NF-1:0][DW-1:0] usr_d;
   logic [NF-1:0]         dirty_d;
   logic [DW-1:0]         rd_c;

   assign wr_fld    = wr_en && (addr < NF_A);
   assign wr_ctl    = wr_en && (addr == CTRL_A);
   assign release_h = wr_ctl && inh_q && !wr_data[INH_BIT];

   always_comb begin
      for (int i = 0; i < NF; i++) begin
         load_mask[i] = (wr_fld && !inh_q && addr == AW'(i)) ||
                        (release_h && dirty_q[i]);
         load_val[i]  = release_h ? usr_q[i] : wr_data;
         if (wr_fld && addr == AW'(i))
            usr_d[i] = wr_data;
         else if (tick && !inh_q)
            usr_d[i] = cnt_d[i];
         else
            usr_d[i] = usr_q[i];
         if (release_h)
            dirty_d[i] = 1'b0;
         else if (wr_fld && inh_q && addr == AW'(i))
            dirty_d[i] = 1'b1;
         else
            dirty_d[i] = dirty_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         usr_q   <= FIELD_FLOOR;
         dirty_q <= '0;
         inh_q   <= 1'b0;
      end else begin
         usr_q   <= usr_d;
         dirty_q <= dirty_d;
         if (wr_ctl) inh_q <= wr_data[INH_BIT];
      end
   end

   always_comb begin
      rd_c = '0;
      if (addr == CTRL_A) rd_c[INH_BIT] = inh_q;
      for (int i = 0; i < NF; i++)
         if (addr == AW'(i)) rd_c = usr_q[i];
   end

   generate
      if (REG_RD) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_c;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_c;
      end
   endgenerate

endmodule

// File: rtl/rtc_shadow_bank.sv
`timescale 1ns/1ps
module rtc_shadow_bank
   import rtc_shadow_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int          DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 14,
   parameter int          INH_BIT   = 3,
   parameter bit          LEAP_EN   = 1'b1,
   parameter bit          REG_RD    = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("rtc_shadow_bank: DATA_W must be 8 for two BCD digits");
      end
      if (INH_BIT < 0 || INH_BIT >= DATA_W) begin : g_bad_bit
         $error("rtc_shadow_bank: INH_BIT outside the data word");
      end
      if (CTRL_ADDR < NF || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_ctl
         $error("rtc_shadow_bank: CTRL_ADDR overlaps fields or exceeds address space");
      end
   endgenerate

   logic [NF-1:0]             load_mask;
   logic [NF-1:0][DATA_W-1:0] load_val;
   logic [NF-1:0][DATA_W-1:0] cnt_q;
   logic [NF-1:0][DATA_W-1:0] cnt_d;
   logic [NF-1:0][DATA_W-1:0] usr_q;
   logic [NF-1:0]             dirty_q;
   logic                      inh_q;

   rtc_time_count #(
      .DW      (DATA_W),
      .LEAP_EN (LEAP_EN)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .load_mask (load_mask),
      .load_val  (load_val),
      .cnt_q     (cnt_q),
      .cnt_d     (cnt_d)
   );

   rtc_user_bank #(
      .AW        (ADDR_W),
      .DW        (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .INH_BIT   (INH_BIT),
      .REG_RD    (REG_RD)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sec_tick),
      .addr      (reg_addr),
      .wr_en     (reg_wr),
      .wr_data   (reg_wdata),
      .cnt_d     (cnt_d),
      .load_mask (load_mask),
      .load_val  (load_val),
      .usr_q     (usr_q),
      .dirty_q   (dirty_q),
      .inh_q     (inh_q),
      .rd_data   (reg_rdata)
   );

endmodule

// File: rtl/rtc_shadow_bank_chk.sv
`timescale 1ns/1ps
module rtc_shadow_bank_chk
   import rtc_shadow_pkg::*;
#(
   parameter int          AW        = 4,
   parameter int          DW        = 8,
   parameter int unsigned CTRL_ADDR = 14,
   parameter int          INH_BIT   = 3
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tick,
   input logic [AW-1:0]         addr,
   input logic                  wr_en,
   input logic [DW-1:0]         wr_data,
   input logic                  inh_q,
   input logic [NF-1:0][DW-1:0] usr_q,
   input logic [NF-1:0][DW-1:0] cnt_q,
   input logic [NF-1:0][DW-1:0] cnt_d,
   input logic [NF-1:0]         dirty_q
);

   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
   localparam logic [AW-1:0] NF_A   = AW'(NF);

   logic fld_wr, ctl_wr, rel;
   assign fld_wr = wr_en && (addr < NF_A);
   assign ctl_wr = wr_en && (addr == CTRL_A);
   assign rel    = ctl_wr && inh_q && !wr_data[INH_BIT];

   assert_tick_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !inh_q) |=> (usr_q == $past(cnt_d)));

   assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q && !fld_wr) |=> $stable(usr_q));

   assert_count_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q && tick && !ctl_wr) |=> (cnt_q != $past(cnt_q)));

   assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel |=> (dirty_q == '0));

   assert_mask_only_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !inh_q |-> (dirty_q == '0));

   generate
      for (genvar i = 0; i < NF; i++) begin : g_fld
         assert_live_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(i) && !inh_q) |=> (cnt_q[i] == $past(wr_data)));
         assert_push_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rel && dirty_q[i]) |=> (cnt_q[i] == $past(usr_q[i])));
      end
   endgenerate

endmodule

bind rtc_shadow_bank rtc_shadow_bank_chk #(
   .AW        (ADDR_W),
   .DW        (DATA_W),
   .CTRL_ADDR (CTRL_ADDR),
   .INH_BIT   (INH_BIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (sec_tick),
   .addr    (reg_addr),
   .wr_en   (reg_wr),
   .wr_data (reg_wdata),
   .inh_q   (inh_q),
   .usr_q   (usr_q),
   .cnt_q   (cnt_q),
   .cnt_d   (cnt_d),
   .dirty_q (dirty_q)
);

// File: tb/rtc_shadow_bank_bench.sv
`timescale 1ns/1ps
module rtc_shadow_bank_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = 4'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   int m_cnt [7];
   int m_usr [7];
   int nx    [7];
   bit m_dirty [7];
   bit m_inh;

   always #2 clk = ~clk;

   rtc_shadow_bank u_rtc_shadow_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [7:0] tobcd(input int v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction

   function automatic int frombcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_in(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic advance_nx();
      nx[0] = nx[0] + 1;
      if (nx[0] > 59) begin
         nx[0] = 0; nx[1] = nx[1] + 1;
         if (nx[1] > 59) begin
            nx[1] = 0; nx[2] = nx[2] + 1;
            if (nx[2] > 23) begin
               nx[2] = 0;
               nx[3] = (nx[3] == 7) ? 1 : nx[3] + 1;
               if (nx[4] >= days_in(nx[5], nx[6])) begin
                  nx[4] = 1; nx[5] = nx[5] + 1;
                  if (nx[5] > 12) begin
                     nx[5] = 1; nx[6] = (nx[6] + 1) % 100;
                  end
               end else nx[4] = nx[4] + 1;
            end
         end
      end
   endtask

   task automatic chk(input string tag, input int reg_no, input logic [7:0] got,
                      input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s reg %0d got %h expected %h", tag, reg_no, got, exp);
      end
   endtask

   task automatic verify(input string tag);
      for (int i = 0; i < 7; i++) begin
         reg_addr = 4'(i);
         #0.2;
         chk(tag, i, reg_rdata, tobcd(m_usr[i]));
      end
      reg_addr = 4'hE;
      #0.2;
      chk("R5 control", 14, reg_rdata, m_inh ? 8'h08 : 8'h00);
      reg_addr = 4'h9;
      #0.2;
      chk("R5 unmapped", 9, reg_rdata, 8'h00);
   endtask

   task automatic step(input string tag, input bit t, input bit w, input int a,
                       input logic [7:0] d);
      bit wc, wctl, rel;
      sec_tick  = t;
      reg_wr    = w;
      reg_addr  = 4'(a);
      reg_wdata = d;
      @(posedge clk);
      #1;
      sec_tick = 1'b0;
      reg_wr   = 1'b0;
      wc   = w && (a < 7);
      wctl = w && (a == 14);
      rel  = wctl && m_inh && !d[3];
      nx = m_cnt;
      if (t) advance_nx();
      if (wc && !m_inh) nx[a] = frombcd(d);
      if (rel) for (int i = 0; i < 7; i++) if (m_dirty[i]) nx[i] = m_usr[i];
      if (t && !m_inh) m_usr = nx;
      if (wc) m_usr[a] = frombcd(d);
      if (rel) for (int i = 0; i < 7; i++) m_dirty[i] = 1'b0;
      if (wc && m_inh) m_dirty[a] = 1'b1;
      if (wctl) m_inh = d[3];
      m_cnt = nx;
      verify(tag);
   endtask

   task automatic set_time(input string tag, input int s, input int mi, input int h,
                           input int wd, input int dt, input int mo, input int yr);
      step(tag, 0, 1, 0, tobcd(s));
      step(tag, 0, 1, 1, tobcd(mi));
      step(tag, 0, 1, 2, tobcd(h));
      step(tag, 0, 1, 3, tobcd(wd));
      step(tag, 0, 1, 4, tobcd(dt));
      step(tag, 0, 1, 5, tobcd(mo));
      step(tag, 0, 1, 6, tobcd(yr));
   endtask

   initial begin
      m_cnt = '{0, 0, 0, 1, 1, 1, 0};
      m_usr = m_cnt;
      for (int i = 0; i < 7; i++) m_dirty[i] = 1'b0;
      m_inh = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      verify("R1 reset");

      // free-running ticks across a minute boundary
      repeat (65) step("R2 R3 ticks", 1, 0, 0, 8'h00);

      // live load then roll weekday, date, month and year together
      set_time("R9 live load", 58, 59, 23, 7, 31, 12, 99);
      repeat (3) step("R3 R4 R9 rollover", 1, 0, 0, 8'h00);

      // every month, plain and leap year: last day reached, then wrap
      for (int yr = 23; yr <= 24; yr++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            set_time("R4 month", 59, 59, 23, 3, days_in(mo, yr) - 1, mo, yr);
            step("R4 month last", 1, 0, 0, 8'h00);
            set_time("R4 month", 59, 59, 23, 3, days_in(mo, yr), mo, yr);
            step("R4 month wrap", 1, 0, 0, 8'h00);
         end
      end

      // every year: February 28th at end of day
      for (int yr = 0; yr < 100; yr++) begin
         set_time("R4 leap", 59, 59, 23, 1, 28, 2, yr);
         step("R4 leap", 1, 0, 0, 8'h00);
      end

      // freeze, tick, write one field, release
      set_time("R6 setup", 5, 20, 10, 2, 15, 6, 30);
      step("R6 freeze", 0, 1, 14, 8'h08);
      repeat (4) step("R6 frozen tick", 1, 0, 0, 8'h00);
      step("R8 held write", 0, 1, 1, 8'h45);
      repeat (2) step("R6 frozen tick", 1, 0, 0, 8'h00);
      step("R8 R10 release", 0, 1, 14, 8'h00);
      step("R8 R10 after release", 1, 0, 0, 8'h00);

      // pulse in the same cycle as setting the hold bit
      step("R7 tick with freeze", 1, 1, 14, 8'h08);
      step("R7 frozen", 1, 0, 0, 8'h00);
      step("R7 release no writes", 0, 1, 14, 8'h00);
      step("R7 resume", 1, 0, 0, 8'h00);

      // release in the same cycle as a pulse
      step("R11 freeze", 0, 1, 14, 8'h08);
      step("R11 held write", 0, 1, 2, 8'h05);
      step("R11 held write", 0, 1, 6, 8'h42);
      step("R11 release with tick", 1, 1, 14, 8'h00);
      step("R11 resume", 1, 0, 0, 8'h00);

      // control and unmapped space
      step("R5 unmapped write", 0, 1, 9, 8'hFF);
      step("R5 other ctl bits", 0, 1, 14, 8'hF7);
      step("R5 set hold", 0, 1, 14, 8'hFF);
      step("R5 unmapped write held", 0, 1, 15, 8'h11);
      step("R5 clear hold", 0, 1, 14, 8'h00);
      step("R5 resume", 1, 0, 0, 8'h00);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule